// File: doc/BRIEF.md
# Supply Event Interrupt Controller

This block gathers the power-management events of a metering chip's supply subsystem into one latched flag register. It keeps a matching enable register and drives a single interrupt line. The events are these:
- the switched rail moves from the main supply to the battery;
- the switched rail moves from the battery back to the main supply;
- the battery reading falls below its threshold, or a new battery reading is ready;
- the DC input drops below its comparator trip point of 1.2 V;
- a DC-input conversion completes, or the DC input moves by more than its delta;
- a line-voltage sag is reported.

The converters, comparators and sag detector sit outside the block, and their results arrive as single-bit inputs.

Software uses a small register bus. Offset 0 holds the flags, and writing 0 to a bit clears that bit. Offset 1 holds the enables. Offset 2 gives the live rail source. Every flag latches whether or not it is enabled, so software can poll events that it has masked from the interrupt. The rail-source input is asynchronous. It passes through a two-flop synchronizer before its edges are detected in both directions.

Top module: `supply_event_irq`

## Requirements
- R1: When railSrc goes from 1 (main) to 0 (battery) and stays there, flag bit 0 is set at the third rising clock edge after the change: two synchronizer stages, then the flag register.
- R2: When railSrc goes from 0 to 1 and stays there, flag bit 1 is set at the third rising edge after the change, and flag bit 0 is not affected.
- R3: Reading offset 2 returns the synchronized rail source in bit 0 (1 = main supply, 0 = battery) and zeros above it. The value follows the input two edges after it changes.
- R4: Flag bit 2 is set at any rising edge where battLow or battReady is high.
- R5: Flag bit 3 is set by dcLow, bit 4 by dcReady, bit 5 by dcDelta and bit 6 by sagEvt, each at the rising edge where the input is high.
- R6: Every flag is set by its event whatever the value of its enable bit.
- R7: A flag stays set until a write to offset 0 carries 0 in that bit position. Writing 1 to a flag bit leaves that bit unchanged.
- R8: If an event and a clearing write to offset 0 hit the same flag at the same edge, the flag ends up set.
- R9: Offset 1 holds the seven enable bits, with bit i enabling flag bit i. Reading it back returns the last value written, with the upper bit as 0. Reading offset 3 returns 0.
- R10: irq is high exactly when some flag bit and its enable bit are both 1. It is a level, active high, and it follows the registers with no extra delay.
- R11: rstN is active low and synchronous. It clears the flags and the enables and loads the rail-source history from railSrc, so leaving reset never sets flag bit 0 or flag bit 1, whatever the rail level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| railSrc | input | 1 | Rail source, asynchronous: 1 = main supply, 0 = battery |
| battLow | input | 1 | Battery reading below its threshold |
| battReady | input | 1 | New battery reading ready, one-cycle strobe |
| dcLow | input | 1 | DC input below the 1.2 V comparator trip point |
| dcReady | input | 1 | DC-input conversion ready, strobe |
| dcDelta | input | 1 | DC-input change exceeded its delta, strobe |
| sagEvt | input | 1 | Line-voltage sag detected, strobe |
| busSel | input | 1 | Bus access this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from busAddr |
| irq | output | 1 | Combined interrupt, active high level |

## Verification
An event strobe and a software write that clears flags can land on the same clock edge. This collision is the case the design must settle. The bench drives sagEvt high in the very cycle that it writes zeros to offset 0, at first with flag bit 6 clear and again with it already set. It then reads the flags back and expects bit 6 to be set both times, while the other bits are cleared by the same write. A follow-up write with no event must then clear the bit, which shows that the write itself was not lost.

// File: rtl/sevt_pkg.sv
package sevt_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 2;
  localparam int NUM_FLAGS   = 7;
  localparam int SYNC_STAGES = 2;
  localparam int PAD_W       = DATA_W - NUM_FLAGS;

  // flag bit positions
  localparam int F_SW_BAT  = 0;
  localparam int F_RESTORE = 1;
  localparam int F_BATT    = 2;
  localparam int F_DC_LOW  = 3;
  localparam int F_DC_RDY  = 4;
  localparam int F_DC_DLT  = 5;
  localparam int F_SAG     = 6;

  localparam logic [ADDR_W-1:0] A_FLAGS = 2'd0;
  localparam logic [ADDR_W-1:0] A_EN    = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;

  typedef enum logic [1:0] {RD_NONE, RD_FLAGS, RD_EN, RD_STAT} rdSel_e;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] evtSet;
    logic                 flagWr;
    logic                 enWr;
    rdSel_e               rdSel;
    logic                 srcLive;
    logic [DATA_W-1:0]    wrData;
  } ctlStrobe_t;
endpackage

// File: rtl/sevt_ctrl.sv
module sevt_ctrl
  import sevt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              railSrc,
  input  logic              battLow,
  input  logic              battReady,
  input  logic              dcLow,
  input  logic              dcReady,
  input  logic              dcDelta,
  input  logic              sagEvt,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output ctlStrobe_t        ctl
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevSrc;
  logic                   srcNow;

  assign srcNow = syncQ[SYNC_STAGES-1];

  // reset loads the history from the live input so no edge is seen on exit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= {SYNC_STAGES{railSrc}};
      prevSrc <= railSrc;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], railSrc};
      prevSrc <= srcNow;
    end
  end

  logic [NUM_FLAGS-1:0] evtVec;
  always_comb begin
    evtVec             = '0;
    evtVec[F_SW_BAT]   = prevSrc & ~srcNow;
    evtVec[F_RESTORE]  = ~prevSrc & srcNow;
    evtVec[F_BATT]     = battLow | battReady;
    evtVec[F_DC_LOW]   = dcLow;
    evtVec[F_DC_RDY]   = dcReady;
    evtVec[F_DC_DLT]   = dcDelta;
    evtVec[F_SAG]      = sagEvt;
  end

  always_comb begin
    ctl.evtSet  = evtVec;
    ctl.flagWr  = busSel & busWe & (busAddr == A_FLAGS);
    ctl.enWr    = busSel & busWe & (busAddr == A_EN);
    ctl.srcLive = srcNow;
    ctl.wrData  = busWdata;
    case (busAddr)
      A_FLAGS: ctl.rdSel = RD_FLAGS;
      A_EN:    ctl.rdSel = RD_EN;
      A_STAT:  ctl.rdSel = RD_STAT;
      default: ctl.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/sevt_regs.sv
module sevt_regs
  import sevt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           ctl,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic [NUM_FLAGS-1:0] enQ,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] flagKeep;

  // a written 0 clears, a written 1 keeps; events are ORed in last so they win
  assign flagKeep = ctl.flagWr ? (flagQ & ctl.wrData[NUM_FLAGS-1:0]) : flagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
    end else begin
      flagQ <= flagKeep | ctl.evtSet;
      if (ctl.enWr) enQ <= ctl.wrData[NUM_FLAGS-1:0];
    end
  end

  assign irq = |(flagQ & enQ);

  always_comb begin
    case (ctl.rdSel)
      RD_FLAGS: rdData = {{PAD_W{1'b0}}, flagQ};
      RD_EN:    rdData = {{PAD_W{1'b0}}, enQ};
      RD_STAT:  rdData = {{(DATA_W-1){1'b0}}, ctl.srcLive};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/supply_event_irq.sv
module supply_event_irq
  import sevt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              railSrc,
  input  logic              battLow,
  input  logic              battReady,
  input  logic              dcLow,
  input  logic              dcReady,
  input  logic              dcDelta,
  input  logic              sagEvt,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  ctlStrobe_t           ctl;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] enQ;

  sevt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .railSrc(railSrc),
    .battLow(battLow), .battReady(battReady), .dcLow(dcLow),
    .dcReady(dcReady), .dcDelta(dcDelta), .sagEvt(sagEvt),
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .ctl(ctl)
  );

  sevt_regs uRegs (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .flagQ(flagQ), .enQ(enQ), .rdData(busRdata), .irq(irq)
  );
endmodule

// File: rtl/supply_event_irq_chk.sv
module supply_event_irq_chk
  import sevt_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 sagEvt,
  input logic                 busSel,
  input logic                 busWe,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busWdata,
  input logic [NUM_FLAGS-1:0] flagQ,
  input logic [NUM_FLAGS-1:0] enQ,
  input logic                 irq
);
  logic clrWr, enWr;
  assign clrWr = busSel & busWe & (busAddr == A_FLAGS);
  assign enWr  = busSel & busWe & (busAddr == A_EN);

  // R5 R8
  sag_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    sagEvt |=> flagQ[F_SAG]);

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // R7
  write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ((flagQ & $past(flagQ & busWdata[NUM_FLAGS-1:0])) ==
               $past(flagQ & busWdata[NUM_FLAGS-1:0])));

  // R9
  enable_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    enWr |=> (enQ == $past(busWdata[NUM_FLAGS-1:0])));

  // R10
  irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((flagQ & enQ) != '0));

  // R10
  irq_when_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((flagQ & enQ) != '0) |-> irq);
endmodule

bind supply_event_irq supply_event_irq_chk uChk (
  .clk(clk), .rstN(rstN), .sagEvt(sagEvt), .busSel(busSel), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .flagQ(flagQ), .enQ(enQ), .irq(irq)
);

// File: tb/supply_event_irq_test.sv
`timescale 1ns/1ps
module supply_event_irq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic railSrc = 1'b1;
  logic battLow = 0, battReady = 0, dcLow = 0, dcReady = 0, dcDelta = 0, sagEvt = 0;
  logic busSel = 0, busWe = 0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  supply_event_irq uut (
    .clk(clk), .rstN(rstN), .railSrc(railSrc), .battLow(battLow),
    .battReady(battReady), .dcLow(dcLow), .dcReady(dcReady), .dcDelta(dcDelta),
    .sagEvt(sagEvt), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // {events[20:15] battLow,battReady,dcLow,dcReady,dcDelta,sag ; enables[14:8] ; expFlags[7:1] ; expIrq[0]}
  localparam logic [20:0] VEC [7] = '{
    {6'b000001, 7'h40, 7'h40, 1'b1},
    {6'b100000, 7'h00, 7'h04, 1'b0},
    {6'b010000, 7'h04, 7'h04, 1'b1},
    {6'b001010, 7'h10, 7'h28, 1'b0},
    {6'b000100, 7'h10, 7'h10, 1'b1},
    {6'b111111, 7'h7F, 7'h7C, 1'b1},
    {6'b000000, 7'h7F, 7'h00, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWe = 0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWe = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    waitEdges(4);
    rstN = 1;
    // R11 reset state
    busRead(2'd0, rd); check("R11 flags after reset", rd, 8'h00);
    busRead(2'd1, rd); check("R11 enables after reset", rd, 8'h00);
    check("R11 irq after reset", irq, 0);
    busRead(2'd2, rd); check("R3 status main after reset", rd, 8'h01);

    // R4 R5 R6 R10 vector table
    for (int v = 0; v < 7; v++) begin
      logic [20:0] t;
      t = VEC[v];
      busWrite(2'd1, {1'b0, t[14:8]});
      busWrite(2'd0, 8'h00);
      @(negedge clk);
      {battLow, battReady, dcLow, dcReady, dcDelta, sagEvt} = t[20:15];
      @(negedge clk);
      {battLow, battReady, dcLow, dcReady, dcDelta, sagEvt} = 6'b0;
      busRead(2'd0, rd);
      check($sformatf("R4 R5 R6 flags vector %0d", v), rd, {1'b0, t[7:1]});
      check($sformatf("R10 irq vector %0d", v), irq, t[0]);
    end
    busWrite(2'd0, 8'h00);

    // R9 enable readback, unmapped offset
    busWrite(2'd1, 8'hFF);
    busRead(2'd1, rd); check("R9 enable readback", rd, 8'h7F);
    busRead(2'd3, rd); check("R9 unmapped reads zero", rd, 8'h00);
    busWrite(2'd1, 8'h00);

    // R1 switchover, R3 status timing
    @(negedge clk); railSrc = 0;
    @(negedge clk); @(negedge clk);
    busSel = 1; busAddr = 2'd0; #1 check("R1 no flag before third edge", busRdata, 8'h00);
    busAddr = 2'd2; #1 check("R3 status follows after two edges", busRdata, 8'h00);
    busSel = 0;
    @(negedge clk);
    busSel = 1; busAddr = 2'd0; #1 check("R1 switchover flag on third edge", busRdata, 8'h01);
    busSel = 0;
    waitEdges(3);
    busRead(2'd0, rd); check("R7 switchover flag latched", rd, 8'h01);

    // R2 restore
    @(negedge clk); railSrc = 1;
    waitEdges(3);
    busRead(2'd0, rd); check("R2 restore flag set, bit 0 kept", rd, 8'h03);
    busRead(2'd2, rd); check("R3 status back to main", rd, 8'h01);

    // R7 write 1 keeps, write 0 clears selectively
    busWrite(2'd0, 8'h7F);
    busRead(2'd0, rd); check("R7 write ones keeps flags", rd, 8'h03);
    busWrite(2'd0, 8'h7E);
    busRead(2'd0, rd); check("R7 write zero clears bit 0 only", rd, 8'h02);

    // R10 irq follows enable on a latched flag
    busWrite(2'd1, 8'h02);
    check("R10 irq raised by enable", irq, 1);
    busWrite(2'd1, 8'h01);
    check("R10 irq dropped by disable", irq, 0);
    busWrite(2'd0, 8'h00);
    busWrite(2'd1, 8'h00);

    // R8 collision: event and clear in the same cycle, flag clear beforehand
    busWrite(2'd0, 8'h00);
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = 2'd0; busWdata = 8'h00; sagEvt = 1;
    @(negedge clk);
    busSel = 0; busWe = 0; sagEvt = 0;
    busRead(2'd0, rd); check("R8 event beats clear (flag was clear)", rd, 8'h40);
    // R8 collision with flag already set and another flag to clear
    @(negedge clk); dcDelta = 1;
    @(negedge clk); dcDelta = 0;
    busSel = 1; busWe = 1; busAddr = 2'd0; busWdata = 8'h00; sagEvt = 1;
    @(negedge clk);
    busSel = 0; busWe = 0; sagEvt = 0;
    busRead(2'd0, rd); check("R8 event beats clear (flag was set)", rd, 8'h40);
    busWrite(2'd0, 8'h00);
    busRead(2'd0, rd); check("R7 plain clear after collision", rd, 8'h00);

    // R11 reset with rail on battery: no edge flags
    @(negedge clk); rstN = 0; railSrc = 0;
    waitEdges(3);
    rstN = 1;
    waitEdges(4);
    busRead(2'd0, rd); check("R11 no rail flags after reset on battery", rd, 8'h00);
    busRead(2'd2, rd); check("R3 R11 status battery after reset", rd, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule